// File: doc/BRIEF.md
# TFT Panel Timing Generator

This block drives the scan timing of a parallel RGB TFT panel. From one system clock it derives a pixel-rate enable. It walks every line through four phases: horizontal sync, back porch, active pixels and front porch. It walks every frame through the same four phases, counted in lines. From these it produces horizontal sync, vertical sync, data enable, gated pixel data and a panel power output. Each output level has its own inversion control.

The block follows the scan with pixel and line coordinates and a linear frame-buffer word address, at one 16-bit word per pixel. An external fetch engine can supply `pixIn` at the right moment from these. A one-cycle frame-start pulse marks the first visible pixel of each frame.

Every timing field is written as the wanted count minus one. The whole configuration is taken from parallel inputs only while the master enable is low. Raising the enable restarts the scan at the top of the vertical sync phase, so the first frame is always complete.

Top module: `tft_timing_gen`

## Requirements
- R1: `pixClkEn` is a one-cycle pulse that repeats every (cfgClkDiv+1)*2 clock cycles; cfgClkDiv = 0 gives a period of 2 cycles.
- R2: Each line is, in order: hsync active for cfgHSync+1 pixel periods, back porch for cfgHBack+1, data enable for cfgPixels+1, and front porch for cfgHFront+1. The line length is the sum of the four.
- R3: Each frame is, in order: vsync active for cfgVSync+1 lines, back porch for cfgVBack+1 lines, cfgLines+1 active lines, and front porch for cfgVFront+1 lines. A vsync edge always falls in the first cycle of an hsync pulse.
- R4: hsync, vsync, de and rgbOut each have their own inversion bit (0 = active high / data as is, 1 = inverted). rgbOut carries pixIn while data enable is active and all zeros otherwise, and the result is XORed with the data inversion bit.
- R5: The configuration inputs are captured only while enable is low; changing them while enabled has no effect until the next disable/enable cycle.
- R6: From the second rising edge after enable is first sampled low, hsync, vsync and de rest at their inactive levels, pixClkEn and frameStart stay low, and panelPwr is low.
- R7: From the rising edge that first samples enable high, the outputs stay inactive for one more edge. At the second edge, hsync and vsync are both active and the first pixel period of a vsync line begins.
- R8: panelPwr is high only while the block runs and the captured cfgPwrOn bit is 1.
- R9: In every pixel period with data enable active, pixX and pixY give the pixel column and active line, both counted from 0. fbAddr equals cfgBase + pixY*(cfgPixels+1) + pixX, and it restarts at cfgBase in every frame.
- R10: frameStart is high for exactly one cycle per frame, in the first cycle of pixel (0,0), together with data enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable; configuration is captured while low |
| cfgClkDiv | input | 10 | Pixel divider; period = (value+1)*2 clocks |
| cfgVBack | input | 8 | Vertical back porch lines minus one |
| cfgLines | input | 10 | Active lines minus one |
| cfgVFront | input | 8 | Vertical front porch lines minus one |
| cfgVSync | input | 6 | Vertical sync lines minus one |
| cfgHBack | input | 7 | Horizontal back porch pixels minus one |
| cfgPixels | input | 11 | Active pixels per line minus one |
| cfgHFront | input | 8 | Horizontal front porch pixels minus one |
| cfgHSync | input | 8 | Horizontal sync pixels minus one |
| cfgInvHsync | input | 1 | Invert hsync |
| cfgInvVsync | input | 1 | Invert vsync |
| cfgInvData | input | 1 | Invert rgbOut |
| cfgInvDe | input | 1 | Invert de |
| cfgPwrOn | input | 1 | Allow panelPwr while running |
| cfgBase | input | 22 | Frame-buffer base word address |
| pixIn | input | 16 | Pixel word from the external fetch |
| pixClkEn | output | 1 | Pixel-rate enable pulse |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| rgbOut | output | 16 | Panel pixel data |
| panelPwr | output | 1 | Panel power enable |
| pixX | output | 11 | Current pixel column |
| pixY | output | 10 | Current active line |
| fbAddr | output | 22 | Frame-buffer word address of the current pixel |
| frameStart | output | 1 | First visible pixel of a frame |

## Verification
The bench builds the block with the default package field widths. It programs tiny porch, sync and size values: a 3-pixel sync, 5-pixel lines and 3 active lines, so a line takes 22 cycles and a frame 154 cycles at the fastest divider. Short frames like these let the bench watch whole frames, restarts after enable, address wrap-back at the frame start and the full phase order many times within a short run. It also uses divider settings 0 and 2, to show that pixel periods stretch evenly and that every phase length scales with the divider.

// File: rtl/tft_pkg.sv
package tft_pkg;

  parameter int DIV_W  = 10;
  parameter int VBP_W  = 8;
  parameter int LINE_W = 10;
  parameter int VFP_W  = 8;
  parameter int VS_W   = 6;
  parameter int HBP_W  = 7;
  parameter int PIX_W  = 11;
  parameter int HFP_W  = 8;
  parameter int HS_W   = 8;
  parameter int ADDR_W = 22;
  parameter int RGB_W  = 16;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int HCNT_W = maxOf(maxOf(HS_W, HBP_W), maxOf(PIX_W, HFP_W));
  localparam int VCNT_W = maxOf(maxOf(VS_W, VBP_W), maxOf(LINE_W, VFP_W));

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  typedef struct packed {
    logic [DIV_W-1:0]  clkDiv;
    logic [VBP_W-1:0]  vBack;
    logic [LINE_W-1:0] lines;
    logic [VFP_W-1:0]  vFront;
    logic [VS_W-1:0]   vSync;
    logic [HBP_W-1:0]  hBack;
    logic [PIX_W-1:0]  pixels;
    logic [HFP_W-1:0]  hFront;
    logic [HS_W-1:0]   hSync;
  } tft_tim_t;

  typedef struct packed {
    logic invHsync;
    logic invVsync;
    logic invData;
    logic invDe;
    logic pwrOn;
  } tft_pol_t;

  typedef struct packed {
    tft_tim_t          tim;
    tft_pol_t          pol;
    logic [ADDR_W-1:0] base;
  } tft_cfg_t;

  // Strobes from the scan control to the output datapath
  typedef struct packed {
    logic run;       // scan is running
    logic pixFirst;  // first system cycle of a pixel period
    logic tick;      // last system cycle of a pixel period
    logic lineWrap;  // tick that ends the front porch of a line
    logic hSync;
    logic vSync;
    logic hAct;
    logic vAct;
  } tft_strb_t;

endpackage

// File: rtl/tft_scan_ctrl.sv
module tft_scan_ctrl
  import tft_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  tft_cfg_t          cfgIn,
  output tft_strb_t         strb,
  output tft_pol_t          polQ,
  output logic [ADDR_W-1:0] baseQ
);

  tft_cfg_t          cfgQ;
  logic              run;
  logic [DIV_W:0]    divCnt;
  logic [DIV_W:0]    divLimit;
  phase_e            hPh;
  phase_e            vPh;
  logic [HCNT_W-1:0] hCnt;
  logic [VCNT_W-1:0] vCnt;
  logic              tick;
  logic              lineWrap;
  logic              startUp;

  function automatic phase_e nextPh(input phase_e p);
    case (p)
      PH_SYNC: return PH_BACK;
      PH_BACK: return PH_ACT;
      PH_ACT:  return PH_FRONT;
      default: return PH_SYNC;
    endcase
  endfunction

  function automatic logic [HCNT_W-1:0] hLoad(input phase_e p, input tft_tim_t t);
    case (p)
      PH_SYNC: return HCNT_W'(t.hSync);
      PH_BACK: return HCNT_W'(t.hBack);
      PH_ACT:  return HCNT_W'(t.pixels);
      default: return HCNT_W'(t.hFront);
    endcase
  endfunction

  function automatic logic [VCNT_W-1:0] vLoad(input phase_e p, input tft_tim_t t);
    case (p)
      PH_SYNC: return VCNT_W'(t.vSync);
      PH_BACK: return VCNT_W'(t.vBack);
      PH_ACT:  return VCNT_W'(t.lines);
      default: return VCNT_W'(t.vFront);
    endcase
  endfunction

  // Period of (clkDiv+1)*2 cycles: count 0 .. 2*clkDiv+1
  assign divLimit = {cfgQ.tim.clkDiv, 1'b1};
  assign tick     = run && (divCnt == divLimit);
  assign lineWrap = tick && (hPh == PH_FRONT) && (hCnt == '0);
  assign startUp  = enable && !run;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= '0;
      run    <= 1'b0;
      divCnt <= '0;
      hPh    <= PH_SYNC;
      vPh    <= PH_SYNC;
      hCnt   <= '0;
      vCnt   <= '0;
    end else begin
      run <= enable;
      if (!enable) cfgQ <= cfgIn;
      if (startUp) begin
        divCnt <= '0;
        hPh    <= PH_SYNC;
        hCnt   <= hLoad(PH_SYNC, cfgQ.tim);
        vPh    <= PH_SYNC;
        vCnt   <= vLoad(PH_SYNC, cfgQ.tim);
      end else if (run && enable) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          if (hCnt == '0) begin
            hPh  <= nextPh(hPh);
            hCnt <= hLoad(nextPh(hPh), cfgQ.tim);
          end else begin
            hCnt <= hCnt - 1'b1;
          end
          if (lineWrap) begin
            if (vCnt == '0) begin
              vPh  <= nextPh(vPh);
              vCnt <= vLoad(nextPh(vPh), cfgQ.tim);
            end else begin
              vCnt <= vCnt - 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    strb.run      = run;
    strb.pixFirst = run && (divCnt == '0);
    strb.tick     = tick;
    strb.lineWrap = lineWrap;
    strb.hSync    = (hPh == PH_SYNC);
    strb.vSync    = (vPh == PH_SYNC);
    strb.hAct     = (hPh == PH_ACT);
    strb.vAct     = (vPh == PH_ACT);
  end

  assign polQ  = cfgQ.pol;
  assign baseQ = cfgQ.base;

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R5
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> $stable(cfgQ));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && enable && !tick) |=> ($stable(hPh) && $stable(vPh)));

  // R3
  vphase_on_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && enable && tick && !lineWrap) |=> $stable(vPh));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startUp |=> (hPh == PH_SYNC && vPh == PH_SYNC && divCnt == '0));

endmodule

// File: rtl/tft_out_path.sv
module tft_out_path
  import tft_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tft_strb_t         strb,
  input  tft_pol_t          pol,
  input  logic [ADDR_W-1:0] base,
  input  logic [RGB_W-1:0]  pixIn,
  output logic              pixClkEn,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [RGB_W-1:0]  rgbOut,
  output logic              panelPwr,
  output logic [PIX_W-1:0]  pixX,
  output logic [LINE_W-1:0] pixY,
  output logic [ADDR_W-1:0] fbAddr,
  output logic              frameStart
);

  logic              active;
  logic              vActive;
  logic [PIX_W-1:0]  xPos;
  logic [LINE_W-1:0] yPos;
  logic [ADDR_W-1:0] addr;

  logic              hsRawQ;
  logic              vsRawQ;
  logic              deRawQ;
  logic              pceQ;
  logic              sofQ;
  logic              pwrQ;
  logic [RGB_W-1:0]  rgbQ;
  logic [PIX_W-1:0]  xQ;
  logic [LINE_W-1:0] yQ;
  logic [ADDR_W-1:0] addrQ;

  assign active  = strb.run && strb.hAct && strb.vAct;
  assign vActive = strb.run && strb.vAct;

  // Scan position trackers, aligned with the control phase registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPos <= '0;
      yPos <= '0;
      addr <= '0;
    end else begin
      if (!active)        xPos <= '0;
      else if (strb.tick) xPos <= xPos + 1'b1;

      if (!vActive)           yPos <= '0;
      else if (strb.lineWrap) yPos <= yPos + 1'b1;

      if (!vActive)                  addr <= base;
      else if (active && strb.tick)  addr <= addr + 1'b1;
    end
  end

  // Output registers, one cycle behind the scan state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsRawQ <= 1'b0;
      vsRawQ <= 1'b0;
      deRawQ <= 1'b0;
      pceQ   <= 1'b0;
      sofQ   <= 1'b0;
      pwrQ   <= 1'b0;
      rgbQ   <= '0;
      xQ     <= '0;
      yQ     <= '0;
      addrQ  <= '0;
    end else begin
      hsRawQ <= strb.run && strb.hSync;
      vsRawQ <= strb.run && strb.vSync;
      deRawQ <= active;
      pceQ   <= strb.pixFirst;
      sofQ   <= active && strb.pixFirst && (xPos == '0) && (yPos == '0);
      pwrQ   <= strb.run && pol.pwrOn;
      rgbQ   <= active ? pixIn : '0;
      xQ     <= xPos;
      yQ     <= yPos;
      addrQ  <= addr;
    end
  end

  assign hsync      = hsRawQ ^ pol.invHsync;
  assign vsync      = vsRawQ ^ pol.invVsync;
  assign de         = deRawQ ^ pol.invDe;
  assign rgbOut     = rgbQ ^ {RGB_W{pol.invData}};
  assign pixClkEn   = pceQ;
  assign frameStart = sofQ;
  assign panelPwr   = pwrQ;
  assign pixX       = xQ;
  assign pixY       = yQ;
  assign fbAddr     = addrQ;

  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pceQ && deRawQ && $past(deRawQ)) |-> (addrQ == $past(addrQ) + 1'b1));

  // R10
  sof_in_de_chk: assert property (@(posedge clk) disable iff (!rstN)
    sofQ |-> (deRawQ && xQ == '0 && yQ == '0 && addrQ == base));

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (!deRawQ && !hsRawQ && !vsRawQ && !pceQ && !pwrQ));

  // R2
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    deRawQ |-> (!hsRawQ && !vsRawQ));

endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
  import tft_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  cfgClkDiv,
  input  logic [VBP_W-1:0]  cfgVBack,
  input  logic [LINE_W-1:0] cfgLines,
  input  logic [VFP_W-1:0]  cfgVFront,
  input  logic [VS_W-1:0]   cfgVSync,
  input  logic [HBP_W-1:0]  cfgHBack,
  input  logic [PIX_W-1:0]  cfgPixels,
  input  logic [HFP_W-1:0]  cfgHFront,
  input  logic [HS_W-1:0]   cfgHSync,
  input  logic              cfgInvHsync,
  input  logic              cfgInvVsync,
  input  logic              cfgInvData,
  input  logic              cfgInvDe,
  input  logic              cfgPwrOn,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [RGB_W-1:0]  pixIn,
  output logic              pixClkEn,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [RGB_W-1:0]  rgbOut,
  output logic              panelPwr,
  output logic [PIX_W-1:0]  pixX,
  output logic [LINE_W-1:0] pixY,
  output logic [ADDR_W-1:0] fbAddr,
  output logic              frameStart
);

  tft_cfg_t          cfgIn;
  tft_strb_t         strb;
  tft_pol_t          polQ;
  logic [ADDR_W-1:0] baseQ;

  always_comb begin
    cfgIn.tim.clkDiv  = cfgClkDiv;
    cfgIn.tim.vBack   = cfgVBack;
    cfgIn.tim.lines   = cfgLines;
    cfgIn.tim.vFront  = cfgVFront;
    cfgIn.tim.vSync   = cfgVSync;
    cfgIn.tim.hBack   = cfgHBack;
    cfgIn.tim.pixels  = cfgPixels;
    cfgIn.tim.hFront  = cfgHFront;
    cfgIn.tim.hSync   = cfgHSync;
    cfgIn.pol.invHsync = cfgInvHsync;
    cfgIn.pol.invVsync = cfgInvVsync;
    cfgIn.pol.invData  = cfgInvData;
    cfgIn.pol.invDe    = cfgInvDe;
    cfgIn.pol.pwrOn    = cfgPwrOn;
    cfgIn.base         = cfgBase;
  end

  tft_scan_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .cfgIn  (cfgIn),
    .strb   (strb),
    .polQ   (polQ),
    .baseQ  (baseQ)
  );

  tft_out_path u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pol        (polQ),
    .base       (baseQ),
    .pixIn      (pixIn),
    .pixClkEn   (pixClkEn),
    .hsync      (hsync),
    .vsync      (vsync),
    .de         (de),
    .rgbOut     (rgbOut),
    .panelPwr   (panelPwr),
    .pixX       (pixX),
    .pixY       (pixY),
    .fbAddr     (fbAddr),
    .frameStart (frameStart)
  );

endmodule

// File: tb/tb_tft_timing_gen.sv
`timescale 1ns/1ps
module tb_tft_timing_gen;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, enable;
  logic [9:0]  cfgClkDiv;
  logic [7:0]  cfgVBack;
  logic [9:0]  cfgLines;
  logic [7:0]  cfgVFront;
  logic [5:0]  cfgVSync;
  logic [6:0]  cfgHBack;
  logic [10:0] cfgPixels;
  logic [7:0]  cfgHFront;
  logic [7:0]  cfgHSync;
  logic        cfgInvHsync, cfgInvVsync, cfgInvData, cfgInvDe, cfgPwrOn;
  logic [21:0] cfgBase;
  logic [15:0] pixIn;

  logic        pixClkEn, hsync, vsync, de, panelPwr, frameStart;
  logic [15:0] rgbOut;
  logic [10:0] pixX;
  logic [9:0]  pixY;
  logic [21:0] fbAddr;

  tft_timing_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgClkDiv(cfgClkDiv), .cfgVBack(cfgVBack), .cfgLines(cfgLines),
    .cfgVFront(cfgVFront), .cfgVSync(cfgVSync), .cfgHBack(cfgHBack),
    .cfgPixels(cfgPixels), .cfgHFront(cfgHFront), .cfgHSync(cfgHSync),
    .cfgInvHsync(cfgInvHsync), .cfgInvVsync(cfgInvVsync),
    .cfgInvData(cfgInvData), .cfgInvDe(cfgInvDe), .cfgPwrOn(cfgPwrOn),
    .cfgBase(cfgBase), .pixIn(pixIn),
    .pixClkEn(pixClkEn), .hsync(hsync), .vsync(vsync), .de(de),
    .rgbOut(rgbOut), .panelPwr(panelPwr), .pixX(pixX), .pixY(pixY),
    .fbAddr(fbAddr), .frameStart(frameStart)
  );

  int checks = 0;
  int fails  = 0;
  localparam logic [15:0] PIXVAL = 16'h3C5A;
  localparam logic [21:0] BASE   = 22'h000100;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not end actual=0 expected=1");
    finishRun();
  end

  // 0 hsync, 1 vsync, 2 de, 3 frameStart, 4 pixClkEn
  function automatic logic sig(input int s);
    case (s)
      0: return hsync;
      1: return vsync;
      2: return de;
      3: return frameStart;
      default: return pixClkEn;
    endcase
  endfunction

  task automatic runLen(input int s, input logic v, output int n);
    n = 0;
    while (sig(s) == v && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic waitFor(input int s, input logic v);
    int g = 0;
    while (sig(s) != v && g < 20000) begin
      g++;
      @(negedge clk);
    end
  endtask

  task automatic setCfg(input int div, input int inv, input int pwr);
    cfgClkDiv = 10'(div);
    cfgHSync = 8'd2;  cfgHBack = 7'd1;  cfgPixels = 11'd4; cfgHFront = 8'd0;
    cfgVSync = 6'd1;  cfgVBack = 8'd0;  cfgLines  = 10'd2; cfgVFront = 8'd0;
    cfgInvHsync = inv[0]; cfgInvVsync = inv[0];
    cfgInvData  = inv[0]; cfgInvDe    = inv[0];
    cfgPwrOn = pwr[0];
    cfgBase  = BASE;
    pixIn    = PIXVAL;
  endtask

  task automatic stopRun();
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Leaves the bench at the first sample of the first hsync pixel
  task automatic startRun();
    @(negedge clk);
    enable = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check(hsync == 0 && vsync == 0 && de == 0, "R6", "idle syncs after reset", {hsync, vsync, de}, 0);
    check(pixClkEn == 0 && frameStart == 0, "R6", "no strobes after reset", {pixClkEn, frameStart}, 0);
    check(panelPwr == 0, "R8", "power low after reset", panelPwr, 0);
  endtask

  task automatic t_start();
    int n;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(hsync == 0 && vsync == 0, "R7", "still idle one edge after enable", {hsync, vsync}, 0);
    @(negedge clk);
    check(hsync == 1 && vsync == 1, "R7", "sync phase at second edge", {hsync, vsync}, 3);
    check(panelPwr == 1, "R8", "power on while running", panelPwr, 1);
    runLen(0, 1'b1, n);
    check(n == 6, "R2", "hsync width cycles", n, 6);
    runLen(0, 1'b0, n);
    check(n == 16, "R2", "hsync low part of line", n, 16);
  endtask

  task automatic t_pixclk(input int period);
    int n;
    waitFor(4, 1'b1);
    runLen(4, 1'b1, n);
    check(n == 1, "R1", "pixClkEn pulse width", n, 1);
    runLen(4, 1'b0, n);
    check(n == period - 1, "R1", "pixClkEn gap", n, period - 1);
  endtask

  task automatic t_line();
    int n;
    waitFor(2, 1'b1);
    check(rgbOut == PIXVAL, "R4", "data passes during de", rgbOut, PIXVAL);
    runLen(2, 1'b1, n);
    check(n == 10, "R2", "de width cycles", n, 10);
    check(rgbOut == 16'h0, "R4", "data zero outside de", rgbOut, 0);
    runLen(0, 1'b0, n);
    check(n == 2, "R2", "front porch cycles", n, 2);
    runLen(0, 1'b1, n);
    check(n == 6, "R2", "hsync width on active line", n, 6);
    runLen(2, 1'b0, n);
    check(n == 4, "R2", "back porch cycles", n, 4);
  endtask

  task automatic t_frame();
    int n;
    waitFor(1, 1'b0);
    waitFor(1, 1'b1);
    check(hsync == 1, "R3", "vsync edge inside hsync", hsync, 1);
    runLen(1, 1'b1, n);
    check(n == 44, "R3", "vsync width cycles", n, 44);
    check(hsync == 1, "R3", "vsync fall at hsync start", hsync, 1);
    runLen(1, 1'b0, n);
    check(n == 110, "R3", "vsync low part of frame", n, 110);
  endtask

  task automatic t_coords();
    int n, ex, ey, npix, errs, cyc;
    waitFor(3, 1'b1);
    check(de == 1 && pixX == 0 && pixY == 0, "R10", "frame start at pixel 0,0", {pixX, pixY}, 0);
    check(fbAddr == BASE, "R9", "address at frame start", fbAddr, BASE);
    runLen(3, 1'b1, n);
    check(n == 1, "R10", "frame start pulse width", n, 1);
    ex = 1; ey = 0; npix = 1; errs = 0; cyc = n;
    while (frameStart == 0 && cyc < 1000) begin
      if (pixClkEn && de) begin
        if (pixX != 11'(ex) || pixY != 10'(ey) || fbAddr != BASE + 22'(ey * 5 + ex)) errs++;
        npix++;
        ex++;
        if (ex == 5) begin ex = 0; ey++; end
      end
      cyc++;
      @(negedge clk);
    end
    check(errs == 0, "R9", "coordinate or address mismatches", errs, 0);
    check(npix == 15, "R9", "visible pixels per frame", npix, 15);
    check(cyc == 154, "R10", "cycles between frame starts", cyc, 154);
    check(fbAddr == BASE, "R9", "address restarts next frame", fbAddr, BASE);
  endtask

  task automatic t_cfgFrozen();
    int n;
    @(negedge clk);
    cfgHSync = 8'd7;
    waitFor(1, 1'b0);
    waitFor(1, 1'b1);
    runLen(0, 1'b1, n);
    check(n == 6, "R5", "sync width ignores live change", n, 6);
    stopRun();
    startRun();
    runLen(0, 1'b1, n);
    check(n == 16, "R5", "sync width taken while disabled", n, 16);
    stopRun();
    cfgHSync = 8'd2;
  endtask

  task automatic t_disable();
    int bad;
    startRun();
    waitFor(2, 1'b1);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(hsync == 0 && vsync == 0 && de == 0, "R6", "idle levels after disable", {hsync, vsync, de}, 0);
    check(panelPwr == 0 && pixClkEn == 0, "R6", "power and strobe off", {panelPwr, pixClkEn}, 0);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      if (pixClkEn || de || hsync || frameStart) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R6", "outputs stay stopped", bad, 0);
  endtask

  task automatic t_polarity();
    int n;
    setCfg(0, 1, 1);
    repeat (3) @(negedge clk);
    check(hsync == 1 && vsync == 1 && de == 1, "R4", "inverted idle levels", {hsync, vsync, de}, 7);
    check(rgbOut == 16'hFFFF, "R4", "inverted idle data", rgbOut, 16'hFFFF);
    startRun();
    check(vsync == 0, "R4", "vsync active low", vsync, 0);
    runLen(0, 1'b0, n);
    check(n == 6, "R4", "inverted hsync width", n, 6);
    waitFor(2, 1'b0);
    check(rgbOut == ~PIXVAL, "R4", "inverted data in de", rgbOut, ~PIXVAL);
    runLen(2, 1'b0, n);
    check(n == 10, "R4", "inverted de width", n, 10);
    check(rgbOut == 16'hFFFF, "R4", "inverted blank data", rgbOut, 16'hFFFF);
    stopRun();
  endtask

  task automatic t_slowClock();
    int n;
    setCfg(2, 0, 1);
    repeat (2) @(negedge clk);
    startRun();
    runLen(0, 1'b1, n);
    check(n == 18, "R2", "hsync width at divider 2", n, 18);
    t_pixclk(6);
    stopRun();
  endtask

  task automatic t_powerOff();
    setCfg(0, 0, 0);
    repeat (2) @(negedge clk);
    startRun();
    repeat (3) @(negedge clk);
    check(panelPwr == 0 && vsync == 1, "R8", "power stays off when not allowed", panelPwr, 0);
    stopRun();
  endtask

  initial begin
    rstN = 1'b0;
    enable = 1'b0;
    setCfg(0, 0, 1);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_start();
    t_pixclk(2);
    t_line();
    t_frame();
    t_coords();
    t_cfgFrozen();
    t_disable();
    t_polarity();
    t_slowClock();
    t_powerOff();
    finishRun();
  end

endmodule